// File: doc/BRIEF.md
# IR Key Learning Sequencer

The block runs the program mode of a remote-controlled power switch. When `prog_req` is seen, the block blinks a two-colour LED to show that the mode has started. It then learns three keys from a remote control, and the frames for those keys come from an RC5 receiver that sits outside the block. The first two keys must be digit keys. Together they give a power-on delay from 00 to 99, where the first key is the tens digit and the second key is the ones digit. The third key must be a non-digit key, and it becomes the power key. The block packs the results into three bytes and writes them to a small non-volatile store. The store uses a single-cycle write strobe and reports when it is busy. After the last write the block asks for the working copies to be reloaded, clears the external key-count register, and goes back to normal mode.

A millisecond tick enable (nominally 1 kHz) drives all timing. If the IR line stays quiet for too long while the block waits for a key, an idle watchdog ends the learning.

States: `S_IDLE` goes to `S_FLASH_RED` on `prog_req`. `S_FLASH_RED` and `S_FLASH_GRN` alternate for `FLASH_PAIRS` pairs. After the last green phase the block enters `S_GET_TENS`. From there the accepted frames lead through these states:
- `S_ACK_TENS` → `S_GET_ONES`
- `S_WR_DELAY` → `S_WT_DELAY` → `S_ACK_ONES` → `S_GET_KEY`
- `S_WR_ADR` → `S_WT_ADR` → `S_WR_CMD` → `S_WT_CMD` → `S_RELOAD` → `S_ACK_KEY` → `S_FINISH` → `S_IDLE`

Each `S_GET_*` state goes to `S_FINISH` if the idle watchdog expires. An ACK state leaves when its LED timer expires. A `S_WT_*` state leaves once `st_busy` is low.

Top module: `ir_learn_seq`

## Requirements
- R1: After reset, both LEDs are off and `in_prog`, `st_wr`, `reload_req` and `keycnt_clr` are low.
- R2: On `prog_req`, red and green light alternately, red first, for `FLASH_PAIRS` pairs. Each colour lasts exactly `FLASH_MS` ticks, and both LEDs are off afterwards.
- R3: The tens frame is accepted only if its masked command (bits 6:0, with the toggle bit 7 removed) is 0 to 9. Other frames are ignored and the block keeps waiting.
- R4: A ones or power-key frame whose full 8-bit command, toggle bit included, equals the command of the last accepted frame is ignored as a key repeat.
- R5: An accepted ones digit (masked 0 to 9) causes a write of tens×10 + ones to store address 0.
- R6: The power-key frame is accepted only if its masked command is above 9. Its 5-bit address, zero-extended, is written to address 1 and then its 7-bit masked command to address 2. Digit frames at this step are ignored.
- R7: A frame with `frm_bad` high is discarded and the current step is unchanged.
- R8: After each accepted frame, green lights for exactly `FLASH_MS` ticks. For the ones frame this follows its write, and for the power-key frame it follows the reload request.
- R9: In each wait step, `SLICES`×`SLICE_MS` ticks with `ir_active` low make the block pulse `keycnt_clr` for one cycle and leave program mode with no write. Any cycle with `ir_active` high restarts this count.
- R10: Every `st_wr` pulse lasts one cycle and is never issued while `st_busy` is high. The next write, or the next step, waits until `st_busy` is low.
- R11: After the third write, `reload_req` pulses once. The green acknowledge follows, then a one-cycle `keycnt_clr`, and then `in_prog` falls.
- R12: Frames that arrive during an LED acknowledge phase are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_ms | input | 1 | One-cycle millisecond tick enable |
| prog_req | input | 1 | Enter program mode (sampled in idle) |
| ir_active | input | 1 | IR line active level; restarts the idle watchdog |
| frm_valid | input | 1 | One-cycle strobe for a decoded frame |
| frm_bad | input | 1 | Receiver marks the frame as invalid |
| frm_addr | input | ADDR_W | Frame address |
| frm_cmd | input | CMD_W | Frame command; MSB is the toggle bit |
| st_busy | input | 1 | Store write in progress |
| led_red | output | 1 | Red LED |
| led_grn | output | 1 | Green LED |
| st_wr | output | 1 | One-cycle store write strobe |
| st_addr | output | 2 | Store byte address |
| st_wdata | output | 8 | Store write data |
| reload_req | output | 1 | Request to refresh the working copies from the store |
| keycnt_clr | output | 1 | Clear pulse for the external key-count register |
| in_prog | output | 1 | High while in program mode |

## Verification
The bench builds the block with `FLASH_MS`=3, `FLASH_PAIRS`=4, `SLICE_MS`=4 and `SLICES`=3, and it issues a tick every fifth clock. With these values a whole learning session fits in a few hundred cycles. That makes it possible to sweep every pair of tens and ones digits, 100 complete sessions, each with its own power-key address and command. Every session also includes a bad frame, a non-digit tens frame, a frame sent during an acknowledge phase, a held-key repeat and a digit sent as the power key. With the short watchdog window, the bench can count idle ticks one by one in the timeout and restart cases.

// File: rtl/ir_learn_pkg.sv
`timescale 1ns/1ps
package ir_learn_pkg;

    localparam int DATA_W  = 8;
    localparam int DIG_MAX = 9;

    typedef enum logic [4:0] {
        S_IDLE,
        S_FLASH_RED,
        S_FLASH_GRN,
        S_GET_TENS,
        S_ACK_TENS,
        S_GET_ONES,
        S_WR_DELAY,
        S_WT_DELAY,
        S_ACK_ONES,
        S_GET_KEY,
        S_WR_ADR,
        S_WT_ADR,
        S_WR_CMD,
        S_WT_CMD,
        S_RELOAD,
        S_ACK_KEY,
        S_FINISH
    } learn_state_t;

    typedef enum logic [1:0] {
        SLOT_DELAY = 2'd0,
        SLOT_KADR  = 2'd1,
        SLOT_KCMD  = 2'd2
    } store_slot_t;

endpackage

// File: rtl/ms_timer.sv
`timescale 1ns/1ps
module ms_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic         expire
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (tick && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expire = tick && (cnt == W'(1));

    // R8
    timer_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !load) |=> (cnt == '0));

endmodule

// File: rtl/idle_wd.sv
`timescale 1ns/1ps
module idle_wd #(
    parameter int SLICE_MS = 262,
    parameter int SLICES   = 19
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic arm,
    input  logic hold,
    output logic expire
);

    localparam int TW = $clog2(SLICE_MS + 1);
    localparam int NW = $clog2(SLICES + 1);

    logic [TW-1:0] tcnt;
    logic [NW-1:0] scnt;
    logic          slice_end;

    assign slice_end = (tcnt == TW'(SLICE_MS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt <= '0;
            scnt <= '0;
        end else if (!arm || hold) begin
            tcnt <= '0;
            scnt <= '0;
        end else if (tick) begin
            if (slice_end) begin
                tcnt <= '0;
                scnt <= scnt + 1'b1;
            end else begin
                tcnt <= tcnt + 1'b1;
            end
        end
    end

    assign expire = arm && !hold && tick && slice_end && (scnt == NW'(SLICES - 1));

    // R9
    slice_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm |-> (scnt < NW'(SLICES)));

    // R9
    hold_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !expire);

endmodule

// File: rtl/frame_check.sv
`timescale 1ns/1ps
module frame_check
    import ir_learn_pkg::*;
#(
    parameter int CMD_W = 8
) (
    input  logic [CMD_W-1:0] cmd,
    input  logic [CMD_W-1:0] prev_cmd,
    output logic [CMD_W-2:0] masked,
    output logic             is_digit,
    output logic             is_key,
    output logic             changed
);

    assign masked   = cmd[CMD_W-2:0];
    assign is_digit = (masked <= (CMD_W-1)'(DIG_MAX));
    assign is_key   = !is_digit;
    assign changed  = (cmd != prev_cmd);

endmodule

// File: rtl/ten_mult.sv
`timescale 1ns/1ps
module ten_mult
    import ir_learn_pkg::*;
(
    input  logic [3:0]        digit,
    output logic [DATA_W-1:0] prod
);

    logic [DATA_W-1:0] d_ext;

    assign d_ext = DATA_W'(digit);
    assign prod  = (d_ext << 3) + d_ext + d_ext;

    // R5
    always_comb begin
        times10_chk: assert (digit > 4'd9 || int'(prod) == int'(digit) * 10);
    end

endmodule

// File: rtl/ir_learn_seq.sv
`timescale 1ns/1ps
module ir_learn_seq
    import ir_learn_pkg::*;
#(
    parameter int CMD_W       = 8,
    parameter int ADDR_W      = 5,
    parameter int FLASH_MS    = 250,
    parameter int FLASH_PAIRS = 4,
    parameter int SLICE_MS    = 262,
    parameter int SLICES      = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_ms,
    input  logic              prog_req,
    input  logic              ir_active,
    input  logic              frm_valid,
    input  logic              frm_bad,
    input  logic [ADDR_W-1:0] frm_addr,
    input  logic [CMD_W-1:0]  frm_cmd,
    input  logic              st_busy,
    output logic              led_red,
    output logic              led_grn,
    output logic              st_wr,
    output logic [1:0]        st_addr,
    output logic [7:0]        st_wdata,
    output logic              reload_req,
    output logic              keycnt_clr,
    output logic              in_prog
);

    localparam int TW = $clog2(FLASH_MS + 1);
    localparam int PW = $clog2(FLASH_PAIRS + 1);

    learn_state_t state, state_nx;

    logic [PW-1:0]     pairs;
    logic [CMD_W-1:0]  prev_cmd;
    logic [DATA_W-1:0] tens10;
    logic [DATA_W-1:0] delay_val;
    logic [ADDR_W-1:0] key_addr;
    logic [CMD_W-2:0]  key_cmd;

    logic              t_load, t_exp;
    logic              wd_arm, wd_exp;
    logic [CMD_W-2:0]  masked;
    logic              is_digit, is_key, changed;
    logic [DATA_W-1:0] tens_prod;
    logic              frm_ok, tens_ok, ones_ok, key_ok;

    frame_check #(.CMD_W(CMD_W)) u_chk (
        .cmd      (frm_cmd),
        .prev_cmd (prev_cmd),
        .masked   (masked),
        .is_digit (is_digit),
        .is_key   (is_key),
        .changed  (changed)
    );

    ten_mult u_mul (
        .digit (masked[3:0]),
        .prod  (tens_prod)
    );

    ms_timer #(.W(TW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (TW'(FLASH_MS)),
        .tick     (tick_ms),
        .expire   (t_exp)
    );

    idle_wd #(.SLICE_MS(SLICE_MS), .SLICES(SLICES)) u_wd (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_ms),
        .arm    (wd_arm),
        .hold   (ir_active),
        .expire (wd_exp)
    );

    assign frm_ok  = frm_valid && !frm_bad;
    assign tens_ok = (state == S_GET_TENS) && frm_ok && is_digit;
    assign ones_ok = (state == S_GET_ONES) && frm_ok && changed && is_digit;
    assign key_ok  = (state == S_GET_KEY)  && frm_ok && changed && is_key;
    assign wd_arm  = (state == S_GET_TENS) || (state == S_GET_ONES) || (state == S_GET_KEY);
    assign t_load  = (state_nx != state);

    // next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:      if (prog_req) state_nx = S_FLASH_RED;
            S_FLASH_RED: if (t_exp) state_nx = S_FLASH_GRN;
            S_FLASH_GRN: if (t_exp) state_nx = (pairs == PW'(FLASH_PAIRS - 1)) ? S_GET_TENS : S_FLASH_RED;
            S_GET_TENS: begin
                if (wd_exp)       state_nx = S_FINISH;
                else if (tens_ok) state_nx = S_ACK_TENS;
            end
            S_ACK_TENS:  if (t_exp) state_nx = S_GET_ONES;
            S_GET_ONES: begin
                if (wd_exp)       state_nx = S_FINISH;
                else if (ones_ok) state_nx = S_WR_DELAY;
            end
            S_WR_DELAY:  state_nx = S_WT_DELAY;
            S_WT_DELAY:  if (!st_busy) state_nx = S_ACK_ONES;
            S_ACK_ONES:  if (t_exp) state_nx = S_GET_KEY;
            S_GET_KEY: begin
                if (wd_exp)      state_nx = S_FINISH;
                else if (key_ok) state_nx = S_WR_ADR;
            end
            S_WR_ADR:    state_nx = S_WT_ADR;
            S_WT_ADR:    if (!st_busy) state_nx = S_WR_CMD;
            S_WR_CMD:    state_nx = S_WT_CMD;
            S_WT_CMD:    if (!st_busy) state_nx = S_RELOAD;
            S_RELOAD:    state_nx = S_ACK_KEY;
            S_ACK_KEY:   if (t_exp) state_nx = S_FINISH;
            S_FINISH:    state_nx = S_IDLE;
            default:     state_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // learned data and flash pair count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pairs     <= '0;
            prev_cmd  <= '0;
            tens10    <= '0;
            delay_val <= '0;
            key_addr  <= '0;
            key_cmd   <= '0;
        end else begin
            if (state == S_IDLE) begin
                pairs <= '0;
            end else if (state == S_FLASH_GRN && t_exp) begin
                pairs <= pairs + 1'b1;
            end
            if (tens_ok) begin
                tens10   <= tens_prod;
                prev_cmd <= frm_cmd;
            end
            if (ones_ok) begin
                delay_val <= tens10 + DATA_W'(masked[3:0]);
                prev_cmd  <= frm_cmd;
            end
            if (key_ok) begin
                key_addr <= frm_addr;
                key_cmd  <= masked;
                prev_cmd <= frm_cmd;
            end
        end
    end

    // outputs
    always_comb begin
        led_red    = 1'b0;
        led_grn    = 1'b0;
        st_wr      = 1'b0;
        st_addr    = SLOT_DELAY;
        st_wdata   = delay_val;
        reload_req = 1'b0;
        keycnt_clr = 1'b0;
        in_prog    = (state != S_IDLE);
        unique case (state)
            S_FLASH_RED: led_red = 1'b1;
            S_FLASH_GRN, S_ACK_TENS, S_ACK_ONES, S_ACK_KEY: led_grn = 1'b1;
            S_WR_DELAY: begin
                st_wr    = 1'b1;
                st_addr  = SLOT_DELAY;
                st_wdata = delay_val;
            end
            S_WR_ADR, S_WT_ADR: begin
                st_wr    = (state == S_WR_ADR);
                st_addr  = SLOT_KADR;
                st_wdata = DATA_W'(key_addr);
            end
            S_WR_CMD, S_WT_CMD: begin
                st_wr    = (state == S_WR_CMD);
                st_addr  = SLOT_KCMD;
                st_wdata = DATA_W'(key_cmd);
            end
            S_RELOAD:   reload_req = 1'b1;
            S_FINISH:   keycnt_clr = 1'b1;
            default: ;
        endcase
    end

    // R10
    wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_wr |=> !st_wr);

    // R10
    wr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_wr |-> !st_busy);

    // R11
    reload_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload_req |=> (led_grn && !reload_req));

    // R9
    clr_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        keycnt_clr |=> !in_prog);

    // R12
    ack_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (led_grn && frm_valid) |=> $stable(prev_cmd));

    // R2
    led_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(led_red && led_grn));

endmodule

// File: tb/tb_ir_learn_seq.sv
`timescale 1ns/1ps
module tb_ir_learn_seq;

    localparam int FMS   = 3;
    localparam int PAIRS = 4;
    localparam int SMS   = 4;
    localparam int NSL   = 3;
    localparam int IDLE_LIM = SMS * NSL;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_ms = 1'b0;
    logic       prog_req = 1'b0;
    logic       ir_active = 1'b0;
    logic       frm_valid = 1'b0;
    logic       frm_bad = 1'b0;
    logic [4:0] frm_addr = '0;
    logic [7:0] frm_cmd = '0;
    logic       st_busy;
    logic       led_red, led_grn, st_wr, reload_req, keycnt_clr, in_prog;
    logic [1:0] st_addr;
    logic [7:0] st_wdata;

    int checks = 0;
    int fails  = 0;

    ir_learn_seq #(
        .CMD_W(8), .ADDR_W(5), .FLASH_MS(FMS), .FLASH_PAIRS(PAIRS),
        .SLICE_MS(SMS), .SLICES(NSL)
    ) dut (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .prog_req(prog_req),
        .ir_active(ir_active), .frm_valid(frm_valid), .frm_bad(frm_bad),
        .frm_addr(frm_addr), .frm_cmd(frm_cmd), .st_busy(st_busy),
        .led_red(led_red), .led_grn(led_grn), .st_wr(st_wr), .st_addr(st_addr),
        .st_wdata(st_wdata), .reload_req(reload_req), .keycnt_clr(keycnt_clr),
        .in_prog(in_prog)
    );

    always #4 clk = ~clk;

    // store model
    logic [7:0] mem [0:3];
    int         bcnt = 0;
    assign st_busy = (bcnt != 0);
    always @(posedge clk) begin
        if (st_wr) begin
            mem[st_addr] <= st_wdata;
            bcnt <= 3;
        end else if (bcnt > 0) begin
            bcnt <= bcnt - 1;
        end
    end

    // tick generator
    initial begin
        forever begin
            repeat (4) @(posedge clk);
            #1 tick_ms = 1'b1;
            @(posedge clk);
            #1 tick_ms = 1'b0;
        end
    end

    // monitors
    int red_ticks, grn_ticks, red_rises, grn_rises, grn_falls;
    int writes, reloads, clrs, wr_busy_err, wr_wide_err, idle_ticks, last_idle;
    logic pr_red = 1'b0, pr_grn = 1'b0, pr_wr = 1'b0;

    task automatic clear_mon();
        red_ticks = 0; grn_ticks = 0; red_rises = 0; grn_rises = 0; grn_falls = 0;
        writes = 0; reloads = 0; clrs = 0; idle_ticks = 0; last_idle = -1;
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (led_red && tick_ms) red_ticks++;
            if (led_grn && tick_ms) grn_ticks++;
            if (led_red && !pr_red) red_rises++;
            if (led_grn && !pr_grn) grn_rises++;
            if (!led_grn && pr_grn) grn_falls++;
            if (st_wr) writes++;
            if (st_wr && st_busy) wr_busy_err++;
            if (st_wr && pr_wr) wr_wide_err++;
            if (reload_req) reloads++;
            if (keycnt_clr) begin
                clrs++;
                last_idle = idle_ticks;
            end else if (in_prog && !led_red && !led_grn) begin
                if (ir_active) idle_ticks = 0;
                else if (tick_ms) idle_ticks++;
            end
            pr_red = led_red; pr_grn = led_grn; pr_wr = st_wr;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input logic bad, input logic [4:0] a, input logic [7:0] c);
        @(posedge clk); #1;
        frm_valid = 1'b1; frm_bad = bad; frm_addr = a; frm_cmd = c;
        @(posedge clk); #1;
        frm_valid = 1'b0; frm_bad = 1'b0;
        repeat (2) @(posedge clk);
    endtask

    task automatic enter();
        clear_mon();
        @(posedge clk); #1 prog_req = 1'b1;
        @(posedge clk); #1 prog_req = 1'b0;
        while (grn_falls < PAIRS) @(negedge clk);
    endtask

    task automatic learn(input int t, input int o);
        int k;
        logic [4:0] a;
        k = 10 + ((t * 10 + o) % 118);
        a = 5'((t + 3 * o) % 32);
        for (int i = 0; i < 4; i++) mem[i] = 8'hEE;
        enter();
        // R2: flash pattern
        chk("R2 red phases", red_rises, PAIRS);
        chk("R2 red ticks", red_ticks, PAIRS * FMS);
        ir_active = 1'b1;
        send(1'b1, 5'd0, {1'b0, 7'((t + 1) % 10)});   // R7 bad frame
        send(1'b0, 5'd0, {1'b0, 7'(10 + t)});          // R3 non-digit tens
        send(1'b0, 5'd0, {1'b0, 7'(t)});
        while (grn_rises < PAIRS + 1) @(negedge clk);
        send(1'b0, 5'd0, {1'b1, 7'((o + 1) % 10)});   // R12 during ack
        while (grn_falls < PAIRS + 1) @(negedge clk);
        send(1'b0, 5'd0, {1'b0, 7'(t)});               // R4 repeat
        send(1'b0, 5'd0, {1'b1, 7'(o)});
        while (grn_falls < PAIRS + 2) @(negedge clk);
        send(1'b0, a, 8'h03);                          // R6 digit as key
        send(1'b1, ~a, {1'b0, 7'(k)});                 // R7 bad key
        send(1'b0, a, {1'b0, 7'(k)});
        while (in_prog) @(negedge clk);
        ir_active = 1'b0;
        chk("R5 delay byte", int'(mem[0]), t * 10 + o);
        chk("R6 key address", int'(mem[1]), int'(a));
        chk("R6 key command", int'(mem[2]), k);
        chk("R10 write count", writes, 3);
        chk("R11 reload count", reloads, 1);
        chk("R11 keycnt clear", clrs, 1);
        chk("R8 green phases", grn_rises, PAIRS + 3);
        chk("R8 green ticks", grn_ticks, (PAIRS + 3) * FMS);
    endtask

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        wr_busy_err = 0; wr_wide_err = 0;
        clear_mon();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1 led_red", int'(led_red), 0);
        chk("R1 led_grn", int'(led_grn), 0);
        chk("R1 in_prog", int'(in_prog), 0);
        chk("R1 st_wr", int'(st_wr), 0);
        chk("R1 reload_req", int'(reload_req), 0);
        chk("R1 keycnt_clr", int'(keycnt_clr), 0);

        for (int t = 0; t < 10; t++)
            for (int o = 0; o < 10; o++)
                learn(t, o);

        // R9: plain timeout
        for (int i = 0; i < 4; i++) mem[i] = 8'hEE;
        enter();
        while (in_prog) @(negedge clk);
        chk("R9 idle ticks to expiry", last_idle, IDLE_LIM);
        chk("R9 no write on timeout", writes, 0);
        chk("R9 keycnt clear", clrs, 1);
        chk("R9 no reload", reloads, 0);

        // R9: activity restarts window
        enter();
        while (idle_ticks < IDLE_LIM - 1) @(negedge clk);
        @(posedge clk); #1 ir_active = 1'b1;
        @(posedge clk); #1 ir_active = 1'b0;
        while (in_prog) @(negedge clk);
        chk("R9 restart window", last_idle, IDLE_LIM);

        // R9: timeout after tens accepted
        enter();
        ir_active = 1'b1;
        send(1'b0, 5'd0, 8'h05);
        while (grn_falls < PAIRS + 1) @(negedge clk);
        ir_active = 1'b0;
        while (in_prog) @(negedge clk);
        chk("R9 timeout at ones step", last_idle, IDLE_LIM);
        chk("R9 no write after tens", writes, 0);
        chk("R9 store untouched", int'(mem[0]), 8'hEE);

        chk("R10 write during busy", wr_busy_err, 0);
        chk("R10 strobe width", wr_wide_err, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule